// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block drives the two switches of a half-bridge from one duty setting. A free-running counter defines the period. The primary drive is active for the first part of each period and the complementary drive is active for the rest. Before either drive turns on, a programmable dead-band count holds it inactive for a number of clock cycles. This gives the opposite switch time to turn off, so both switches never conduct together.

Period and duty are copied into shadow registers only when a period ends. Software can therefore rewrite them at any time without corrupting the period in progress. A polarity select for each output inverts that output after the dead band has been inserted. The inactive level of an output is the level of its polarity select.

Top module: `halfbridge_pwm`

## Requirements
- R1: While running, the period counter counts 0, 1, …, P and then returns to 0, so a period lasts P+1 cycles. `cycle_start` is high for one cycle at the start of each period, in the same cycle in which the drives show counter value 0. Drives and `cycle_start` show the counter state one clock after it.
- R2: Before the dead band is applied, the primary drive is active while the counter is below the shadow duty D. If D is 0 it is never active. If D is larger than P it is always active.
- R3: Before the dead band is applied, the complementary drive is active exactly when the primary drive is not, that is, while the counter is at least D.
- R4: Each drive becomes active only after its underlying on-time has been asserted for `dead_i` consecutive cycles. The first `dead_i` cycles of every on-time are held inactive.
- R5: When `dead_i` is at least the length of an on-time, that drive stays inactive for the whole period.
- R6: The two drives are never active in the same cycle, whatever the settings.
- R7: With `dead_i` = 0 and the block running, exactly one drive is active in every cycle.
- R8: Each pin equals its active state XOR its polarity input (`pol_a` for the primary, `pol_b` for the complementary). The inactive level therefore equals the polarity input.
- R9: When `en` is low, both drives sit at their inactive level, `cycle_start` is low and the counter is held at 0. After `en` rises, the first period starts from count 0.
- R10: A change to `period_i` or `duty_i` during a period takes effect only from the next period.
- R11: While `rst` is high, both drives are at their inactive level and `cycle_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the outputs idle |
| period_i | input | CNT_W | Period value P (period is P+1 cycles) |
| duty_i | input | CNT_W | Duty value D (primary on while count < D) |
| dead_i | input | DEAD_W | Dead-band length in cycles |
| pol_a | input | 1 | Primary polarity; 1 inverts, also sets the idle level |
| pol_b | input | 1 | Complementary polarity; 1 inverts, also sets the idle level |
| drv_a | output | 1 | Primary drive |
| drv_b | output | 1 | Complementary drive |
| cycle_start | output | 1 | One-cycle pulse marking count 0 of each period |

## Verification
Once `en` is seen high at a clock edge, the counter spends its first period cycle at 0. The pins and `cycle_start` for that cycle appear one edge later, so the k-th sample taken after the second edge reflects count k mod (P+1). The bench samples a quarter period after each rising edge. It computes each expected drive from the count position, from D, and from the length of the on-time already elapsed. After `en` falls, idle levels are expected from the second edge on. Shadow updates are checked by changing period and duty in the middle of the first period and expecting the old values up to and including sample P.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int DEAD_W = 7;
  localparam int NUM_CH = 2;
  localparam int CH_PRI = 0;
  localparam int CH_CMP = 1;
  typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/hb_timebase.sv
module hb_timebase
  import hb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output ch_vec_t          raw_o,
  output logic             start_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] duty_q;
  logic             run_q;
  logic             at_end;
  logic             reload;
  logic             pri_on;

  assign at_end = (cnt_q == per_q);
  // shadows follow inputs while idle, on the first run cycle, and at wrap
  assign reload = !en || !run_q || at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (reload) begin
        per_q  <= period_i;
        duty_q <= duty_i;
      end
      if (!en) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (!run_q) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (at_end) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pri_on          = (cnt_q < duty_q);
  assign raw_o[CH_PRI]   = run_q && pri_on;
  assign raw_o[CH_CMP]   = run_q && !pri_on;
  assign start_o         = run_q && (cnt_q == '0);
endmodule

// File: rtl/hb_dead_gate.sv
module hb_dead_gate #(
  parameter int DEAD_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              act_o
);
  // number of earlier consecutive cycles raw_i has been high (saturating)
  logic [DEAD_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst || !raw_i) begin
      held_q <= '0;
    end else if (held_q != {DEAD_W{1'b1}}) begin
      held_q <= held_q + 1'b1;
    end
  end

  assign act_o = raw_i && (held_q >= dead_i);
endmodule

// File: rtl/hb_drive.sv
module hb_drive (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic pol_i,
  output logic drv_o
);
  always_ff @(posedge clk) begin
    if (rst) drv_o <= pol_i;
    else     drv_o <= act_i ^ pol_i;
  end
endmodule

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm
  import hb_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DEAD_W = hb_pkg::DEAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  duty_i,
  input  logic [DEAD_W-1:0] dead_i,
  input  logic              pol_a,
  input  logic              pol_b,
  output logic              drv_a,
  output logic              drv_b,
  output logic              cycle_start
);
  ch_vec_t raw;
  ch_vec_t act;
  ch_vec_t pol;
  ch_vec_t drv;
  logic    start_c;
  logic    start_q;

  assign pol[CH_PRI] = pol_a;
  assign pol[CH_CMP] = pol_b;

  hb_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .period_i (period_i),
    .duty_i   (duty_i),
    .raw_o    (raw),
    .start_o  (start_c)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    hb_dead_gate #(.DEAD_W(DEAD_W)) u_gate (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw[g]),
      .dead_i (dead_i),
      .act_o  (act[g])
    );
    hb_drive u_drv (
      .clk   (clk),
      .rst   (rst),
      .act_i (act[g]),
      .pol_i (pol[g]),
      .drv_o (drv[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start_c;
  end

  assign drv_a       = drv[CH_PRI];
  assign drv_b       = drv[CH_CMP];
  assign cycle_start = start_q;
endmodule

// File: rtl/halfbridge_pwm_chk.sv
module halfbridge_pwm_chk #(
  parameter int DEAD_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [DEAD_W-1:0] dead_i,
  input logic              pol_a,
  input logic              pol_b,
  input logic              drv_a,
  input logic              drv_b,
  input logic              cycle_start
);
  logic pa_q, pb_q, act_a, act_b;

  always_ff @(posedge clk) begin
    pa_q <= pol_a;
    pb_q <= pol_b;
  end

  assign act_a = drv_a ^ pa_q;
  assign act_b = drv_b ^ pb_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(act_a && act_b)); // R6

  AST_GAP_A_TO_B: assert property (@(posedge clk) disable iff (rst)
    ($past(act_a) && ($past(dead_i) != '0)) |-> !act_b); // R4

  AST_GAP_B_TO_A: assert property (@(posedge clk) disable iff (rst)
    ($past(act_b) && ($past(dead_i) != '0)) |-> !act_a); // R4

  AST_ZERO_DEAD_COMPL: assert property (@(posedge clk) disable iff (rst)
    ($past(en, 2) && !$past(rst) && !$past(rst, 2) && ($past(dead_i) == '0))
      |-> (act_a ^ act_b)); // R7

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !$past(en, 2) |-> (!act_a && !act_b && !cycle_start)); // R9

  AST_START_RUNNING: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> $past(en, 2)); // R1
endmodule

bind halfbridge_pwm halfbridge_pwm_chk #(.DEAD_W(DEAD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .dead_i      (dead_i),
  .pol_a       (pol_a),
  .pol_b       (pol_b),
  .drv_a       (drv_a),
  .drv_b       (drv_b),
  .cycle_start (cycle_start)
);

// File: tb/halfbridge_pwm_test.sv
module halfbridge_pwm_test;
  localparam int CLK_NS = 10;
  localparam int Q      = CLK_NS / 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] period_i = '0;
  logic [7:0] duty_i   = '0;
  logic [6:0] dead_i   = '0;
  logic       pol_a = 1'b0;
  logic       pol_b = 1'b0;
  logic       drv_a, drv_b, cycle_start;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  halfbridge_pwm uut (
    .clk(clk), .rst(rst), .en(en), .period_i(period_i), .duty_i(duty_i),
    .dead_i(dead_i), .pol_a(pol_a), .pol_b(pol_b),
    .drv_a(drv_a), .drv_b(drv_b), .cycle_start(cycle_start)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #Q;
  endtask

  // expected active state of a drive at sample k after the first run edge
  function automatic bit exp_act(int ch, int k, int p_val, int d_val, int dd);
    int p;
    p = k % (p_val + 1);
    if (ch == 0) begin
      if (d_val > p_val) return (k >= dd);
      return (p < d_val) && (p >= dd);
    end
    if (d_val == 0) return (k >= dd);
    return (p >= d_val) && ((p - d_val) >= dd);
  endfunction

  task automatic check_idle(input string req);
    check({req, " drv_a idle"}, int'(drv_a), int'(pol_a));
    check({req, " drv_b idle"}, int'(drv_b), int'(pol_b));
    check({req, " start idle"}, int'(cycle_start), 0);
  endtask

  task automatic run_combo(input int pv, input int dv, input int dd,
                           input bit pa, input bit pb, input int n);
    bit ea, eb;
    string ra, rb;
    period_i = 8'(pv); duty_i = 8'(dv); dead_i = 7'(dd);
    pol_a = pa; pol_b = pb;
    tick();
    check_idle("R8");
    en = 1'b1;
    tick();
    check_idle("R9");
    for (int k = 0; k < n; k++) begin
      tick();
      ea = exp_act(0, k, pv, dv, dd);
      eb = exp_act(1, k, pv, dv, dd);
      ra = (dd == 0) ? "R2" : ((dv <= pv && dd >= dv) ? "R5" : "R4");
      rb = (dd == 0) ? "R3" : ((dv != 0 && dd >= pv + 1 - dv) ? "R5" : "R4");
      check(ra, int'(drv_a), int'(ea ^ pa));
      check(rb, int'(drv_b), int'(eb ^ pb));
      check("R1 start", int'(cycle_start), int'((k % (pv + 1)) == 0));
      check("R6 overlap", int'((drv_a ^ pa) && (drv_b ^ pb)), 0);
      if (dd == 0) check("R7 complement", int'((drv_a ^ pa) ^ (drv_b ^ pb)), 1);
    end
    en = 1'b0;
    tick();
    tick();
    check_idle("R9");
  endtask

  initial begin
    #(CLK_NS * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int dlist[6];
    int idx;
    dlist = '{0, 1, 2, 3, 4, 127};
    pol_a = 1'b1; pol_b = 1'b0;
    tick(); tick(); tick();
    check_idle("R11");
    rst = 1'b0;
    tick();

    idx = 0;
    for (int pv = 0; pv <= 6; pv++) begin
      for (int dv = 0; dv <= pv + 2; dv++) begin
        for (int di = 0; di < 6; di++) begin
          run_combo(pv, dv, dlist[di], idx[0], idx[1], 3 * (pv + 1) + 2);
          idx++;
        end
      end
    end

    // R10: period/duty rewritten in the middle of the first period
    period_i = 8'd5; duty_i = 8'd2; dead_i = '0; pol_a = 1'b0; pol_b = 1'b0;
    tick();
    en = 1'b1;
    tick();
    for (int k = 0; k < 16; k++) begin
      int p, d;
      tick();
      if (k < 6) begin p = k; d = 2; end
      else begin p = (k - 6) % 4; d = 3; end
      check("R10 drv_a", int'(drv_a), int'(p < d));
      check("R10 drv_b", int'(drv_b), int'(p >= d));
      check("R10 start", int'(cycle_start), int'(p == 0));
      if (k == 1) begin period_i = 8'd3; duty_i = 8'd3; end
    end
    en = 1'b0;
    tick(); tick();
    check_idle("R9");

    // R11: reset in the middle of a run
    en = 1'b1; period_i = 8'd4; duty_i = 8'd2;
    tick(); tick(); tick();
    rst = 1'b1;
    tick();
    check_idle("R11");
    rst = 1'b0; en = 1'b0;
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule